// File: doc/BRIEF.md
# Memory Copy Channel Engine

This block is a single memory-to-memory copy channel run from a 32-bit register port. Software loads a source address, a destination address and a byte count, then sets the run bit. The engine copies the data one 32-bit word at a time over a request/acknowledge memory port: it reads a source word, then writes it to the destination. On the final word of a count that is not a multiple of four, the write carries a byte-enable mask. When the copy ends, a sticky completion flag is raised, and the interrupt output follows that flag gated by an enable bit.

The run bit also serves as the busy indicator, and it drops by itself when the engine goes idle. Three controls stop the engine. A warm reset aborts the current copy, keeps the programmed addresses and count, and clears itself. A hard reset wipes every register and holds the engine idle for as long as it is set. A flush stops the engine and blocks new starts until software clears it.

Top module: `memcpy_chan`

## Requirements
- R1: After reset, every register offset reads 0, `irq` is 0 and `mem_req` is 0.
- R2: The following register offsets read back what was written: 0x1C source low, 0x60 source high, 0x20 destination low, 0x64 destination high, 0x24 count, 0x28 spare count. Both count registers keep only bits 27:0. Each high word keeps only ADDR_W-32 bits, and those bits become byte-address bits ADDR_W-1:32.
- R3: Writing 1 to bit 0 of offset 0x08 starts a copy when the engine is idle. Bit 0 of 0x08 reads 1 while the copy runs and 0 once it ends.
- R4: A copy reads the word at byte address {high,low}>>2 and writes it to the matching destination word. Both addresses then step by one word, and this repeats until the count is used up. The low two address bits are ignored. `mem_addr` is the word address, so bits 37:30 carry the high word when ADDR_W is 40.
- R5: Every write uses `mem_be` = 4'hF, except the last write of a count whose remainder r = count mod 4 is not zero. That write uses the low r bits set, with bit i enabling byte i (bits 8i+7:8i).
- R6: A copy started with a count of 0 issues no memory access and still sets the completion flag.
- R7: Bit 0 of offset 0x00 is set when a copy ends. Only a write of 0 to that bit clears it. Writing 1 to it has no effect.
- R8: `irq` is 1 exactly when the flag and bit 0 of offset 0x04 were both 1 on the previous cycle.
- R9: Writing 1 to bit 0 of offset 0x0C aborts a running copy, after which no further memory access occurs. The run bit and reset bit 0 return to 0, the address and count registers keep their values, and the flag stays unchanged.
- R10: While bit 1 of offset 0x0C is 1, every other register, including interrupt enable and the flag, is held at 0 and the engine stays idle. Bit 1 itself remains until software writes 0 to it.
- R11: Setting bit 0 of offset 0x14 stops a running copy without setting the flag. While that bit is 1, writes to the run bit do not start a copy. The bit reads back until software clears it.
- R12: Once `mem_req` is raised, it and its address, write strobe and data stay stable until `mem_ack`. Each acknowledge moves exactly one word, so a count of n bytes takes ceil(n/4) writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_addr | input | 8 | Register write byte offset |
| reg_wr_data | input | 32 | Register write data |
| reg_rd_en | input | 1 | Register read strobe |
| reg_rd_addr | input | 8 | Register read byte offset |
| reg_rd_data | output | 32 | Read data, valid the cycle after the strobe |
| irq | output | 1 | Completion interrupt |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | ADDR_W-2 | Word address |
| mem_wdata | output | 32 | Write data |
| mem_be | output | 4 | Write byte enables |
| mem_ack | input | 1 | Access accepted this cycle |
| mem_rdata | input | 32 | Read data, valid with the acknowledge |

## Verification
A wrong remaining-count or address counter shows up at the destination memory as a missing, extra or shifted word. It also shows up as a wrong byte mask on the final write, which is visible as soon as the copy ends. A stuck state register appears within a few cycles: either the run bit never drops or memory requests continue after an abort. A flag or gating error is visible on `irq` one cycle after the flag changes.

// File: rtl/memcpy_pkg.sv
package memcpy_pkg;
  typedef enum logic [1:0] {MV_IDLE, MV_RD, MV_WR} mv_state_t;

  localparam int REG_AW = 8;
  localparam logic [REG_AW-1:0] OFS_FLAG   = 8'h00;
  localparam logic [REG_AW-1:0] OFS_IE     = 8'h04;
  localparam logic [REG_AW-1:0] OFS_RUN    = 8'h08;
  localparam logic [REG_AW-1:0] OFS_RST    = 8'h0C;
  localparam logic [REG_AW-1:0] OFS_FLUSH  = 8'h14;
  localparam logic [REG_AW-1:0] OFS_SRC_LO = 8'h1C;
  localparam logic [REG_AW-1:0] OFS_DST_LO = 8'h20;
  localparam logic [REG_AW-1:0] OFS_CNT    = 8'h24;
  localparam logic [REG_AW-1:0] OFS_CNT2   = 8'h28;
  localparam logic [REG_AW-1:0] OFS_SRC_HI = 8'h60;
  localparam logic [REG_AW-1:0] OFS_DST_HI = 8'h64;
endpackage

// File: rtl/memcpy_mover.sv
module memcpy_mover
  import memcpy_pkg::*;
#(
  parameter int ADDR_W = 40,
  parameter int LEN_W  = 28,
  parameter int DATA_W = 32
) (
  input  logic                                    clk,
  input  logic                                    rst,
  input  logic                                    abort,
  input  logic                                    start,
  input  logic [ADDR_W-1:0]                       src_addr,
  input  logic [ADDR_W-1:0]                       dst_addr,
  input  logic [LEN_W-1:0]                        xfer_len,
  output logic                                    busy,
  output logic                                    done,
  output logic                                    mem_req,
  output logic                                    mem_we,
  output logic [ADDR_W-$clog2(DATA_W/8)-1:0]      mem_addr,
  output logic [DATA_W-1:0]                       mem_wdata,
  output logic [DATA_W/8-1:0]                     mem_be,
  input  logic                                    mem_ack,
  input  logic [DATA_W-1:0]                       mem_rdata
);
  localparam int BYTES = DATA_W / 8;
  localparam int SH    = $clog2(BYTES);
  localparam int WA_W  = ADDR_W - SH;

  mv_state_t          state_q;
  logic [WA_W-1:0]    src_q, dst_q;
  logic [LEN_W-1:0]   rem_q;
  logic [DATA_W-1:0]  data_q;
  logic               done_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= MV_IDLE;
      src_q   <= '0;
      dst_q   <= '0;
      rem_q   <= '0;
      data_q  <= '0;
      done_q  <= 1'b0;
    end else if (abort) begin
      state_q <= MV_IDLE;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        MV_IDLE: if (start) begin
          if (xfer_len == '0) begin
            done_q <= 1'b1;
          end else begin
            src_q   <= src_addr[ADDR_W-1:SH];
            dst_q   <= dst_addr[ADDR_W-1:SH];
            rem_q   <= xfer_len;
            state_q <= MV_RD;
          end
        end
        MV_RD: if (mem_ack) begin
          data_q  <= mem_rdata;
          state_q <= MV_WR;
        end
        MV_WR: if (mem_ack) begin
          if (rem_q <= LEN_W'(BYTES)) begin
            state_q <= MV_IDLE;
            done_q  <= 1'b1;
          end else begin
            rem_q   <= rem_q - LEN_W'(BYTES);
            src_q   <= src_q + 1'b1;
            dst_q   <= dst_q + 1'b1;
            state_q <= MV_RD;
          end
        end
        default: state_q <= MV_IDLE;
      endcase
    end
  end

  always_comb begin
    for (int i = 0; i < BYTES; i++) mem_be[i] = (LEN_W'(i) < rem_q);
  end

  assign busy      = (state_q != MV_IDLE);
  assign done      = done_q;
  assign mem_req   = busy;
  assign mem_we    = (state_q == MV_WR);
  assign mem_addr  = (state_q == MV_WR) ? dst_q : src_q;
  assign mem_wdata = data_q;

  assert_abort_idle_R9: assert property (@(posedge clk) disable iff (rst)
    abort |=> !busy);
  assert_req_held_R12: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack && !abort) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));
  assert_zero_len_R6: assert property (@(posedge clk) disable iff (rst)
    (start && !abort && !busy && xfer_len == '0) |=> (done && !mem_req));
  assert_done_cause_R7: assert property (@(posedge clk) disable iff (rst)
    done |-> ($past(start) || $past(mem_req && mem_we && mem_ack)));
endmodule

// File: rtl/memcpy_regs.sv
module memcpy_regs
  import memcpy_pkg::*;
#(
  parameter int ADDR_W = 40,
  parameter int LEN_W  = 28
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [REG_AW-1:0]  wr_addr,
  input  logic [31:0]        wr_data,
  input  logic               rd_en,
  input  logic [REG_AW-1:0]  rd_addr,
  output logic [31:0]        rd_data,
  output logic               irq,
  input  logic               busy,
  input  logic               done,
  output logic               start,
  output logic               abort,
  output logic               hard,
  output logic [ADDR_W-1:0]  src_addr,
  output logic [ADDR_W-1:0]  dst_addr,
  output logic [LEN_W-1:0]   xfer_len
);
  localparam int HI_W = ADDR_W - 32;

  logic              flag_q, ie_q, warm_q, hard_q, flush_q, irq_q;
  logic [31:0]       src_lo_q, dst_lo_q, rd_q, rd_mux;
  logic [HI_W-1:0]   src_hi_q, dst_hi_q;
  logic [LEN_W-1:0]  cnt_q, cnt2_q;

  function automatic logic hit(input logic [REG_AW-1:0] ofs);
    return wr_en && (wr_addr == ofs);
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      hard_q <= 1'b0;
    end else if (hit(OFS_RST)) begin
      hard_q <= wr_data[1];
    end
  end

  always_ff @(posedge clk) begin
    if (rst || hard_q) begin
      flag_q   <= 1'b0;
      ie_q     <= 1'b0;
      warm_q   <= 1'b0;
      flush_q  <= 1'b0;
      src_lo_q <= '0;
      dst_lo_q <= '0;
      src_hi_q <= '0;
      dst_hi_q <= '0;
      cnt_q    <= '0;
      cnt2_q   <= '0;
    end else begin
      if (done) flag_q <= 1'b1;
      else if (hit(OFS_FLAG) && !wr_data[0]) flag_q <= 1'b0;
      if (hit(OFS_IE))     ie_q     <= wr_data[0];
      if (hit(OFS_RST))    warm_q   <= wr_data[0];
      else if (warm_q && !busy) warm_q <= 1'b0;
      if (hit(OFS_FLUSH))  flush_q  <= wr_data[0];
      if (hit(OFS_SRC_LO)) src_lo_q <= wr_data;
      if (hit(OFS_DST_LO)) dst_lo_q <= wr_data;
      if (hit(OFS_SRC_HI)) src_hi_q <= wr_data[HI_W-1:0];
      if (hit(OFS_DST_HI)) dst_hi_q <= wr_data[HI_W-1:0];
      if (hit(OFS_CNT))    cnt_q    <= wr_data[LEN_W-1:0];
      if (hit(OFS_CNT2))   cnt2_q   <= wr_data[LEN_W-1:0];
    end
  end

  always_comb begin
    rd_mux = '0;
    case (rd_addr)
      OFS_FLAG:   rd_mux = {31'b0, flag_q};
      OFS_IE:     rd_mux = {31'b0, ie_q};
      OFS_RUN:    rd_mux = {31'b0, busy};
      OFS_RST:    rd_mux = {30'b0, hard_q, warm_q};
      OFS_FLUSH:  rd_mux = {31'b0, flush_q};
      OFS_SRC_LO: rd_mux = src_lo_q;
      OFS_DST_LO: rd_mux = dst_lo_q;
      OFS_SRC_HI: rd_mux = 32'(src_hi_q);
      OFS_DST_HI: rd_mux = 32'(dst_hi_q);
      OFS_CNT:    rd_mux = 32'(cnt_q);
      OFS_CNT2:   rd_mux = 32'(cnt2_q);
      default:    rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_q  <= '0;
      irq_q <= 1'b0;
    end else begin
      if (rd_en) rd_q <= rd_mux;
      irq_q <= flag_q & ie_q;
    end
  end

  assign rd_data  = rd_q;
  assign irq      = irq_q;
  assign start    = hit(OFS_RUN) && wr_data[0] && !busy && !warm_q && !flush_q && !hard_q;
  assign abort    = warm_q | flush_q;
  assign hard     = hard_q;
  assign src_addr = {src_hi_q, src_lo_q};
  assign dst_addr = {dst_hi_q, dst_lo_q};
  assign xfer_len = cnt_q;

  assert_irq_gate_R8: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(flag_q && ie_q));
  assert_flag_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    (flag_q && !hard_q && !(hit(OFS_FLAG) && !wr_data[0])) |=> flag_q);
  assert_hard_clear_R10: assert property (@(posedge clk) disable iff (rst)
    hard_q |=> (!busy && !flag_q && !ie_q && !flush_q));
  assert_flush_blocks_R11: assert property (@(posedge clk) disable iff (rst)
    flush_q |-> !start);
endmodule

// File: rtl/memcpy_chan.sv
module memcpy_chan
  import memcpy_pkg::*;
#(
  parameter int ADDR_W = 40,
  parameter int LEN_W  = 28
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 reg_wr_en,
  input  logic [7:0]           reg_wr_addr,
  input  logic [31:0]          reg_wr_data,
  input  logic                 reg_rd_en,
  input  logic [7:0]           reg_rd_addr,
  output logic [31:0]          reg_rd_data,
  output logic                 irq,
  output logic                 mem_req,
  output logic                 mem_we,
  output logic [ADDR_W-3:0]    mem_addr,
  output logic [31:0]          mem_wdata,
  output logic [3:0]           mem_be,
  input  logic                 mem_ack,
  input  logic [31:0]          mem_rdata
);
  logic              busy, done, start, abort, hard;
  logic [ADDR_W-1:0] src_addr, dst_addr;
  logic [LEN_W-1:0]  xfer_len;

  memcpy_regs #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_regs (
    .clk(clk), .rst(rst),
    .wr_en(reg_wr_en), .wr_addr(reg_wr_addr), .wr_data(reg_wr_data),
    .rd_en(reg_rd_en), .rd_addr(reg_rd_addr), .rd_data(reg_rd_data),
    .irq(irq), .busy(busy), .done(done), .start(start), .abort(abort),
    .hard(hard), .src_addr(src_addr), .dst_addr(dst_addr), .xfer_len(xfer_len)
  );

  memcpy_mover #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .DATA_W(32)) u_mover (
    .clk(clk), .rst(rst | hard), .abort(abort), .start(start),
    .src_addr(src_addr), .dst_addr(dst_addr), .xfer_len(xfer_len),
    .busy(busy), .done(done),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_be(mem_be), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
  );
endmodule

// File: tb/memcpy_chan_tb.sv
module memcpy_chan_tb;
  localparam int ADDR_W = 40;
  localparam int WA_W = ADDR_W - 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic reg_wr_en = 1'b0, reg_rd_en = 1'b0;
  logic [7:0] reg_wr_addr = '0, reg_rd_addr = '0;
  logic [31:0] reg_wr_data = '0;
  logic [31:0] reg_rd_data;
  logic irq, mem_req, mem_we, mem_ack = 1'b0;
  logic [WA_W-1:0] mem_addr;
  logic [31:0] mem_wdata, mem_rdata;
  logic [3:0] mem_be;

  int checks = 0, errors = 0, cycles = 0;
  int acc_cnt = 0, wr_cnt = 0, hi_bad = 0;
  logic [3:0] last_be = '0;
  logic [7:0] exp_hi = '0;
  logic [31:0] mem [256];
  logic [31:0] expm [256];

  always #5 clk = ~clk;

  memcpy_chan #(.ADDR_W(ADDR_W), .LEN_W(28)) u_dut (
    .clk(clk), .rst(rst),
    .reg_wr_en(reg_wr_en), .reg_wr_addr(reg_wr_addr), .reg_wr_data(reg_wr_data),
    .reg_rd_en(reg_rd_en), .reg_rd_addr(reg_rd_addr), .reg_rd_data(reg_rd_data),
    .irq(irq), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_be(mem_be), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
  );

  assign mem_rdata = mem[mem_addr[7:0]];

  always @(negedge clk) mem_ack = mem_req && ($urandom_range(3) != 0);

  always @(posedge clk) begin
    if (!rst && mem_req && mem_ack) begin
      acc_cnt = acc_cnt + 1;
      if (mem_addr[WA_W-1:30] != exp_hi) hi_bad = hi_bad + 1;
      if (mem_we) begin
        wr_cnt = wr_cnt + 1;
        last_be = mem_be;
        for (int b = 0; b < 4; b++)
          if (mem_be[b]) mem[mem_addr[7:0]][8*b +: 8] = mem_wdata[8*b +: 8];
      end
    end
  end

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles = cycles + 1;
    if (cycles > 150000) begin
      errors = errors + 1;
      $display("FAIL R3 watchdog expired act=%0d exp<150000", cycles);
      summary();
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      errors = errors + 1;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_wr_addr = a; reg_wr_data = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_rd_en = 1'b1; reg_rd_addr = a;
    @(negedge clk);
    reg_rd_en = 1'b0;
    d = reg_rd_data;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_done();
    logic [31:0] v;
    for (int i = 0; i < 3000; i++) begin
      rd(8'h08, v);
      if (v[0] == 1'b0) break;
    end
  endtask

  function automatic logic [3:0] tail_mask(input int len);
    int r = len % 4;
    return (r == 0) ? 4'hF : 4'((1 << r) - 1);
  endfunction

  function automatic void model_copy(input int sw, input int dw, input int len);
    int left = len;
    for (int k = 0; left > 0; k++) begin
      logic [3:0] be = (left >= 4) ? 4'hF : tail_mask(left);
      for (int b = 0; b < 4; b++)
        if (be[b]) expm[(dw + k) % 256][8*b +: 8] = expm[(sw + k) % 256][8*b +: 8];
      left = left - 4;
    end
  endfunction

  task automatic fill_mem();
    for (int i = 0; i < 256; i++) begin
      mem[i] = $urandom;
      expm[i] = mem[i];
    end
  endtask

  task automatic copy_and_check(input string tag, input int sw, input int dw, input int len, input logic [7:0] hi);
    logic [31:0] v;
    int mism = 0;
    int w0;
    fill_mem();
    exp_hi = hi;
    model_copy(sw, dw, len);
    wr(8'h00, 0);
    wr(8'h04, 1);
    wr(8'h1C, sw * 4);
    wr(8'h60, {24'b0, hi});
    wr(8'h20, dw * 4);
    wr(8'h64, {24'b0, hi});
    wr(8'h24, len);
    w0 = wr_cnt;
    hi_bad = 0;
    wr(8'h08, 1);
    rd(8'h08, v);
    chk({tag, " R3 run bit busy"}, v, 32'd1);
    wait_done();
    rd(8'h08, v);
    chk({tag, " R3 run bit cleared"}, v, 32'd0);
    for (int i = 0; i < 256; i++) if (mem[i] !== expm[i]) mism++;
    chk({tag, " R4 memory image mismatches"}, mism, 0);
    chk({tag, " R12 writes per word"}, wr_cnt - w0, (len + 3) / 4);
    chk({tag, " R5 last byte enables"}, {28'b0, last_be}, {28'b0, tail_mask(len)});
    chk({tag, " R4 high address bits"}, hi_bad, 0);
    rd(8'h00, v);
    chk({tag, " R7 flag set"}, v, 32'd1);
    idle(2);
    chk({tag, " R8 irq asserted"}, {31'b0, irq}, 32'd1);
  endtask

  initial begin
    logic [31:0] v;
    logic [7:0] ofs [11] = '{8'h00, 8'h04, 8'h08, 8'h0C, 8'h14, 8'h1C,
                             8'h20, 8'h24, 8'h28, 8'h60, 8'h64};
    int a0;
    void'($urandom(32'd20240611));
    fill_mem();
    repeat (5) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    for (int i = 0; i < 11; i++) begin
      rd(ofs[i], v);
      chk("R1 register reset value", v, 0);
    end
    chk("R1 irq low", {31'b0, irq}, 0);
    chk("R1 no request", {31'b0, mem_req}, 0);

    // R2 readback and masking
    wr(8'h1C, 32'h1234_5670); rd(8'h1C, v); chk("R2 source low", v, 32'h1234_5670);
    wr(8'h60, 32'hFFFF_FFAB); rd(8'h60, v); chk("R2 source high masked", v, 32'hAB);
    wr(8'h20, 32'hCAFE_0004); rd(8'h20, v); chk("R2 destination low", v, 32'hCAFE_0004);
    wr(8'h64, 32'h0000_0107); rd(8'h64, v); chk("R2 destination high masked", v, 32'h07);
    wr(8'h24, 32'hFFFF_FFFF); rd(8'h24, v); chk("R2 count masked", v, 32'h0FFF_FFFF);
    wr(8'h28, 32'hF123_4567); rd(8'h28, v); chk("R2 spare count masked", v, 32'h0123_4567);

    // R4/R5 directed lengths, then random
    copy_and_check("len4", 3, 140, 4, 8'h00);
    copy_and_check("len1", 10, 150, 1, 8'h00);
    copy_and_check("len7", 20, 130, 7, 8'h00);
    copy_and_check("highaddr", 5, 160, 22, 8'h05);
    for (int k = 0; k < 10; k++)
      copy_and_check("random", $urandom % 48, 128 + ($urandom % 48), 1 + ($urandom % 64), 8'h00);

    // R7 write 1 leaves flag, write 0 clears; R8 irq follows
    wr(8'h00, 1); rd(8'h00, v); chk("R7 write one keeps flag", v, 1);
    wr(8'h04, 0); idle(2); chk("R8 irq gated by enable", {31'b0, irq}, 0);
    wr(8'h04, 1); idle(2); chk("R8 irq re-enabled", {31'b0, irq}, 1);
    wr(8'h00, 0); rd(8'h00, v); chk("R7 write zero clears flag", v, 0);
    idle(2); chk("R8 irq drops with flag", {31'b0, irq}, 0);
    wr(8'h00, 1); rd(8'h00, v); chk("R7 write one does not set flag", v, 0);

    // R6 zero length
    a0 = acc_cnt;
    wr(8'h24, 0); wr(8'h08, 1); idle(3);
    chk("R6 no access for zero count", acc_cnt - a0, 0);
    rd(8'h00, v); chk("R6 flag set on zero count", v, 1);

    // R9 warm reset
    wr(8'h00, 0);
    wr(8'h1C, 32'h40); wr(8'h60, 0); wr(8'h20, 32'h200); wr(8'h64, 0); wr(8'h24, 200);
    exp_hi = 0;
    wr(8'h08, 1); idle(10);
    wr(8'h0C, 1); idle(5);
    rd(8'h08, v); chk("R9 run bit cleared by warm reset", v, 0);
    rd(8'h0C, v); chk("R9 warm bit self-clears", v, 0);
    rd(8'h1C, v); chk("R9 source kept", v, 32'h40);
    rd(8'h24, v); chk("R9 count kept", v, 200);
    rd(8'h00, v); chk("R9 flag unchanged", v, 0);
    a0 = acc_cnt; idle(20);
    chk("R9 no access after abort", acc_cnt - a0, 0);

    // R11 flush
    wr(8'h08, 1); idle(10);
    wr(8'h14, 1); idle(5);
    rd(8'h08, v); chk("R11 run bit cleared by flush", v, 0);
    wr(8'h08, 1);
    rd(8'h08, v); chk("R11 start ignored while flushing", v, 0);
    a0 = acc_cnt; idle(20);
    chk("R11 no access while flushing", acc_cnt - a0, 0);
    rd(8'h00, v); chk("R11 flag not set by flush", v, 0);
    rd(8'h14, v); chk("R11 flush bit reads back", v, 1);
    wr(8'h14, 0);

    // R10 hard reset
    wr(8'h04, 1); wr(8'h24, 0); wr(8'h08, 1); idle(3);
    wr(8'h24, 300); wr(8'h08, 1); idle(4);
    wr(8'h0C, 2); idle(3);
    chk("R10 irq cleared", {31'b0, irq}, 0);
    chk("R10 engine idle", {31'b0, mem_req}, 0);
    rd(8'h0C, v); chk("R10 hard bit held", v, 2);
    wr(8'h0C, 0);
    for (int i = 0; i < 11; i++) begin
      rd(ofs[i], v);
      chk("R10 register cleared", v, 0);
    end

    summary();
  end
endmodule